// File: doc/BRIEF.md
# Ping-pong two-bit-per-step SAR controller

This block is the digital successive-approximation controller of a 9-bit converter built from two capacitive DAC channels that take turns and one shared backend comparator bank. The channel-select input names the channel in conversion. The other channel samples. While it samples, its bottom plates sit at common mode, and a dedicated first-bit comparator delivers its most significant bit before any charge is moved.

When the channels swap, the newly converting channel shows its first bit on its switch word. It then resolves two bits per step strobe from a three-comparator thermometer bank. Four such steps complete the word: the first step adds two bits to the first bit, giving three, and the remaining three steps give two each. The assembled word is registered with a channel tag and announced by a one-cycle valid pulse. Non-monotone thermometer codes are resolved by their count of ones and raise a sticky error flag.

Top module: `sar_pingpong_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, both switch words are all zero (common mode), result_o is 0, and result_valid_o and bubble_err_o are low.
- R2: chan_sel_i = c means channel c converts and the other channel samples. The switch word of the sampling channel is all zero at all times.
- R3: A pulse on fb_valid_i stores fb_bit_i as result bit 8 of the sampling channel. Once that channel converts, its group 8 shows the stored bit.
- R4: Each switch word holds one 2-bit group per result bit, with group i at bits [2i+1:2i]. The codes are 00 for common mode (undecided), 10 for a decided 1 and 01 for a decided 0. Code 11 never appears.
- R5: therm_i bit 0 is the lowest threshold. The valid codes decode as 000 to pair 00, 001 to 01, 011 to 10 and 111 to 11.
- R6: A non-monotone code (010, 100, 101, 110) decodes to its number of ones as the pair. It sets bubble_err_o one cycle after the strobe, and the flag stays high until reset.
- R7: The k-th step strobe (k = 0..3) on the converting channel decides result bits 7-2k (from the upper pair bit) and 6-2k (from the lower pair bit). Higher bits are decided first.
- R8: In the cycle after the fourth step strobe, result_o holds the channel's 9 bits, result_chan_o holds the channel, and result_valid_o is high for exactly one cycle. Bits that were never decided read 0.
- R9: Step strobes after the fourth change neither the switch words nor the result, and raise no valid pulse, until the channel has sampled again.
- R10: fb_valid_i never alters the converting channel. A channel that leaves conversion has all of its decided bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_sel_i | input | 1 | Index of the converting channel |
| fb_valid_i | input | 1 | First-bit decision strobe for the sampling channel |
| fb_bit_i | input | 1 | First-bit comparator output |
| step_i | input | 1 | Two-bit step strobe for the converting channel |
| therm_i | input | 3 | Thermometer outputs of the backend comparators |
| dac_sw0_o | output | 18 | Switch word of channel 0 |
| dac_sw1_o | output | 18 | Switch word of channel 1 |
| result_o | output | 9 | Last completed conversion word |
| result_chan_o | output | 1 | Channel that produced result_o |
| result_valid_o | output | 1 | One-cycle pulse for a new result |
| bubble_err_o | output | 1 | Sticky non-monotone thermometer flag |

## Verification
Every decided bit reaches a switch group the cycle after its strobe. A wrong step counter or a wrong bit position therefore shows up as a misplaced or missing group code within one cycle, before the result even forms. A lost clear on leaving conversion shows as stale groups once the channel converts again, or as stale high bits in its next result. Decode errors show as wrong pair codes on the same cycle. A wrong step count shows as a valid pulse that comes early, comes late or does not come at all.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic [1:0] {
    SW_CM = 2'b00,
    SW_DN = 2'b01,
    SW_UP = 2'b10
  } sw_code_e;
endpackage

// File: rtl/sar_therm_dec.sv
module sar_therm_dec #(
  parameter int W = 3,
  localparam int PW = $clog2(W + 1)
) (
  input  logic [W-1:0]  therm_i,
  output logic [PW-1:0] pair_o,
  output logic          bubble_o
);
  always_comb begin
    pair_o = '0;
    for (int i = 0; i < W; i++) pair_o = pair_o + PW'(therm_i[i]);
  end
  // monotone codes have the form 2^k-1
  assign bubble_o = (therm_i & (therm_i + W'(1))) != '0;
endmodule

// File: rtl/sar_chan.sv
module sar_chan
  import sar_ctrl_pkg::*;
#(
  parameter int NUM_STEPS = 4,
  localparam int RES = 1 + 2 * NUM_STEPS
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           conv_i,
  input  logic           fb_valid_i,
  input  logic           fb_bit_i,
  input  logic           step_i,
  input  logic [1:0]     pair_i,
  output logic [2*RES-1:0] sw_o,
  output logic           done_o,
  output logic [RES-1:0] word_o
);
  localparam int CW = $clog2(NUM_STEPS + 1);

  logic           conv_q;
  logic [RES-1:0] bits_q, mask_q, bits_d, mask_d;
  logic [CW-1:0]  cnt_q;
  logic           take, enter_smp;
  int             hi;

  assign take      = conv_i && step_i && (cnt_q != CW'(NUM_STEPS));
  assign enter_smp = conv_q && !conv_i;
  assign done_o    = take && (cnt_q == CW'(NUM_STEPS - 1));
  assign word_o    = bits_d;

  always_comb begin
    bits_d = bits_q;
    mask_d = mask_q;
    hi     = RES - 2 - 2 * int'(cnt_q);
    if (take) begin
      for (int i = 0; i < RES; i++) begin
        if (i == hi) begin
          bits_d[i] = pair_i[1];
          mask_d[i] = 1'b1;
        end else if (i == hi - 1) begin
          bits_d[i] = pair_i[0];
          mask_d[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q <= 1'b0;
      bits_q <= '0;
      mask_q <= '0;
      cnt_q  <= '0;
    end else begin
      conv_q <= conv_i;
      if (enter_smp) begin
        bits_q <= '0;
        mask_q <= '0;
        cnt_q  <= '0;
      end else if (take) begin
        bits_q <= bits_d;
        mask_q <= mask_d;
        cnt_q  <= cnt_q + CW'(1);
      end
      if (!conv_i && fb_valid_i) begin
        bits_q[RES-1] <= fb_bit_i;
        mask_q[RES-1] <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < RES; g++) begin : g_grp
    assign sw_o[2*g+:2] = (conv_i && mask_q[g]) ? (bits_q[g] ? SW_UP : SW_DN) : SW_CM;
  end
endmodule

// File: rtl/sar_pingpong_ctrl.sv
module sar_pingpong_ctrl #(
  parameter int NUM_STEPS = 4,
  parameter int THERM_W = 3,
  localparam int RES = 1 + 2 * NUM_STEPS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               chan_sel_i,
  input  logic               fb_valid_i,
  input  logic               fb_bit_i,
  input  logic               step_i,
  input  logic [THERM_W-1:0] therm_i,
  output logic [2*RES-1:0]   dac_sw0_o,
  output logic [2*RES-1:0]   dac_sw1_o,
  output logic [RES-1:0]     result_o,
  output logic               result_chan_o,
  output logic               result_valid_o,
  output logic               bubble_err_o
);
  localparam int PW = $clog2(THERM_W + 1);

  logic [PW-1:0]    pair;
  logic             bubble;
  logic [2*RES-1:0] sw   [2];
  logic [RES-1:0]   word [2];
  logic [1:0]       done;

  sar_therm_dec #(.W(THERM_W)) u_dec (
    .therm_i (therm_i),
    .pair_o  (pair),
    .bubble_o(bubble)
  );

  for (genvar c = 0; c < 2; c++) begin : g_ch
    sar_chan #(.NUM_STEPS(NUM_STEPS)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .conv_i    (chan_sel_i == 1'(c)),
      .fb_valid_i(fb_valid_i),
      .fb_bit_i  (fb_bit_i),
      .step_i    (step_i),
      .pair_i    (pair[1:0]),
      .sw_o      (sw[c]),
      .done_o    (done[c]),
      .word_o    (word[c])
    );
  end

  assign dac_sw0_o = sw[0];
  assign dac_sw1_o = sw[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o       <= '0;
      result_chan_o  <= 1'b0;
      result_valid_o <= 1'b0;
      bubble_err_o   <= 1'b0;
    end else begin
      result_valid_o <= |done;
      if (done[1]) begin
        result_o      <= word[1];
        result_chan_o <= 1'b1;
      end else if (done[0]) begin
        result_o      <= word[0];
        result_chan_o <= 1'b0;
      end
      if (step_i && bubble) bubble_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int RES = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chan_sel_i,
  input logic [2*RES-1:0] dac_sw0_o,
  input logic [2*RES-1:0] dac_sw1_o,
  input logic             result_chan_o,
  input logic             result_valid_o,
  input logic             bubble_err_o
);
  logic illegal;
  always_comb begin
    illegal = 1'b0;
    for (int g = 0; g < RES; g++)
      if (dac_sw0_o[2*g+:2] == 2'b11 || dac_sw1_o[2*g+:2] == 2'b11) illegal = 1'b1;
  end

  assert_sampling_cm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_sel_i ? (dac_sw0_o == '0) : (dac_sw1_o == '0));

  assert_no_code11_R4: assert property (@(posedge clk_i) disable iff (!rst_ni) !illegal);

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_err_o |=> bubble_err_o);

  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  assert_valid_tag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> result_chan_o == $past(chan_sel_i));
endmodule

bind sar_pingpong_ctrl sar_ctrl_chk #(.RES(RES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .chan_sel_i    (chan_sel_i),
  .dac_sw0_o     (dac_sw0_o),
  .dac_sw1_o     (dac_sw1_o),
  .result_chan_o (result_chan_o),
  .result_valid_o(result_valid_o),
  .bubble_err_o  (bubble_err_o)
);

// File: tb/tb_sar_pingpong_ctrl.sv
module tb_sar_pingpong_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RES = 9;
  localparam int STEPS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, fb_v = 1'b0, fb_b = 1'b0, step = 1'b0;
  logic [2:0] therm = '0;
  logic [2*RES-1:0] sw0, sw1;
  logic [RES-1:0] res;
  logic res_ch, res_v, err;

  int n_chk = 0, n_err = 0;
  logic [RES-1:0] m_bits [2];
  logic [RES-1:0] m_mask [2];
  int m_cnt [2];
  logic m_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_pingpong_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .chan_sel_i(sel), .fb_valid_i(fb_v), .fb_bit_i(fb_b),
    .step_i(step), .therm_i(therm), .dac_sw0_o(sw0), .dac_sw1_o(sw1), .result_o(res),
    .result_chan_o(res_ch), .result_valid_o(res_v), .bubble_err_o(err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*RES-1:0] exp_sw(int ch);
    logic [2*RES-1:0] w = '0;
    if (ch != int'(sel)) return w;
    for (int g = 0; g < RES; g++)
      if (m_mask[ch][g]) w[2*g+:2] = m_bits[ch][g] ? 2'b10 : 2'b01;
    return w;
  endfunction

  function automatic logic [1:0] dec_pair(logic [2:0] t);
    return 2'(t[0]) + 2'(t[1]) + 2'(t[2]);
  endfunction

  function automatic logic is_bubble(logic [2:0] t);
    return !(t == 3'b000 || t == 3'b001 || t == 3'b011 || t == 3'b111);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_words(string req);
    check(req, 32'(sw0), 32'(exp_sw(0)));
    check(req, 32'(sw1), 32'(exp_sw(1)));
  endtask

  task automatic do_fb(logic b);
    int s = 1 - int'(sel);
    fb_v = 1'b1; fb_b = b;
    tick();
    fb_v = 1'b0;
    m_bits[s][RES-1] = b; m_mask[s][RES-1] = 1'b1;
    check_words("R3/R10 fb on sampling channel only");
  endtask

  task automatic do_step(logic [2:0] t);
    int c = int'(sel);
    logic last = 1'b0;
    logic [1:0] p = dec_pair(t);
    step = 1'b1; therm = t;
    tick();
    step = 1'b0;
    if (is_bubble(t)) m_err = 1'b1;
    if (m_cnt[c] < STEPS) begin
      int hi = RES - 2 - 2 * m_cnt[c];
      m_bits[c][hi] = p[1]; m_bits[c][hi-1] = p[0];
      m_mask[c][hi] = 1'b1; m_mask[c][hi-1] = 1'b1;
      m_cnt[c]++;
      last = (m_cnt[c] == STEPS);
    end
    check_words("R5/R7 words after step");
    check("R6 bubble flag", 32'(err), 32'(m_err));
    check("R8/R9 valid after step", 32'(res_v), 32'(last));
    if (last) begin
      check("R8 result", 32'(res), 32'(m_bits[c]));
      check("R8 channel tag", 32'(res_ch), 32'(c));
      tick();
      check("R8 one-cycle valid", 32'(res_v), 32'd0);
    end
  endtask

  task automatic swap();
    int old = int'(sel);
    sel = ~sel;
    #1;
    m_bits[old] = '0; m_mask[old] = '0; m_cnt[old] = 0;
    check_words("R2 swap words");
    tick();
    check_words("R10 after swap");
  endtask

  logic done = 1'b0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < 2; c++) begin m_bits[c] = '0; m_mask[c] = '0; m_cnt[c] = 0; end
    #3;
    check("R1 reset sw0", 32'(sw0), 32'd0);
    check("R1 reset valid", 32'(res_v), 32'd0);
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
    check("R1 sw1", 32'(sw1), 32'd0);
    check("R1 result", 32'(res), 32'd0);
    check("R1 err", 32'(err), 32'd0);
    // directed: channel 0 converts without a first bit, channel 1 samples
    do_fb(1'b1);
    check("R2 sampling word zero", 32'(sw1), 32'd0);
    do_step(3'b001);
    do_step(3'b011);
    do_step(3'b111);
    do_step(3'b000);
    do_step(3'b111);           // R9 extra strobe ignored
    do_fb(1'b0);               // R10 lands on channel 1 only
    swap();
    check("R3 msb group", 32'(sw1[2*RES-1 -: 2]), 32'd1);
    do_step(3'b010);           // R6 bubble
    do_step(3'b101);
    do_step(3'b110);
    do_step(3'b100);
    swap();
    // random ping-pong
    for (int k = 0; k < 60; k++) begin
      do_fb(1'($urandom));
      for (int s = 0; s < STEPS; s++) begin
        logic [2:0] t = 3'($urandom);
        if ($urandom % 4 != 0)
          case ($urandom % 4) 0: t = 3'b000; 1: t = 3'b001; 2: t = 3'b011; default: t = 3'b111; endcase
        do_step(t);
        if ($urandom % 5 == 0) tick();
      end
      if ($urandom % 4 == 0) do_step(3'b011);
      swap();
    end
    rst_n = 1'b0;
    #2;
    check("R1 reset clears err", 32'(err), 32'd0);
    check("R1 reset clears words", 32'(sw0 | sw1), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule